// File: doc/BRIEF.md
# Descriptor Channel Sequencer

This block runs one crypto-offload channel, one descriptor at a time. Software queues descriptor addresses into a four-slot pointer queue. The sequencer takes the oldest address and reads the first word of the descriptor, which is the header. It then asks the resource controller for the execution units named in the header and waits for a grant. Only after the grant does it read the input word, start the unit and wait for it to finish.

When the unit is done, the sequencer stores the result. It then writes the header back with its completion flag set. If the header asks for it, it also writes a separate word that reports whether the integrity check passed. Last, it returns the units to the controller and goes back for the next queued address.

The pointer port is a valid/ready stream. `ptr_ready` is high whenever a slot is free. A beat offered while `ptr_ready` is low is discarded rather than stalled, so software need not hold `ptr_valid`. The memory port is a valid/ready request channel. While `mem_valid` is high and `mem_ready` is low, the sequencer holds the address, direction and write data steady. A read returns its data on `mem_rdata` in the same cycle that `mem_ready` is high. The unit reservation and start/done signals are plain handshakes.

Top module: `chan_seq`

## Requirements
- R1: After reset `ptr_ready` is 1, `ptr_overflow` is 0, and `mem_valid`, `eu_req`, `eu_start` and `eu_rel` are 0. The sequencer issues no memory request until at least one address has been queued.
- R2: The queue holds 4 addresses. A `ptr_valid` beat while `ptr_ready` is 0 is discarded and sets `ptr_overflow`, which stays at 1 until reset.
- R3: The first memory request for a descriptor is a read at the queued address P, and the word read back is the header.
- R4: Header bits [3:0] hold the primary unit code and bits [7:4] hold the secondary unit code. A code k in the range 1..NUM_EU sets bit k-1 of `eu_mask`. Code 0, or a code above NUM_EU, sets no bit. The secondary code counts only when snoop mode (header bits [9:8]) is non-zero.
- R5: `eu_req` stays high with a stable `eu_mask` until `eu_gnt` is seen. No memory request is issued while `eu_req` is high, and none is issued between the header read and the grant.
- R6: After the grant the sequencer reads the input word at P+4. It then presents that word on `eu_din` with a one-cycle `eu_start` pulse, and `eu_snoop` equals header bits [9:8].
- R7: When `eu_done` is seen after the start, the sequencer writes `eu_dout` to P+8.
- R8: After the output write, the sequencer writes the header to P with bit 31 set and all other bits unchanged.
- R9: Only when header bit 10 is 1, the sequencer then writes a status word to P+12: bit 0 is the `eu_icv_ok` value sampled with `eu_done`, and bits [31:1] are 0.
- R10: After the last writeback, `eu_rel` pulses for one cycle with `eu_mask` equal to the mask that was granted.
- R11: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R12: Queued descriptors are processed whole and in the order their addresses were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_valid | input | 1 | Descriptor address offered |
| ptr_data | input | ADDR_W | Descriptor address |
| ptr_ready | output | 1 | Queue has a free slot |
| ptr_overflow | output | 1 | Sticky: a beat was discarded |
| eu_req | output | 1 | Reservation request to controller |
| eu_mask | output | NUM_EU | Units requested / released |
| eu_gnt | input | 1 | Reservation granted |
| eu_rel | output | 1 | Release pulse |
| eu_start | output | 1 | Start pulse to unit |
| eu_snoop | output | 2 | Snoop mode from header |
| eu_din | output | DATA_W | Input word for unit |
| eu_done | input | 1 | Unit finished |
| eu_dout | input | DATA_W | Unit result |
| eu_icv_ok | input | 1 | Integrity check passed |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Request accepted and completed |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |

## Verification
The assertions assume the controller raises `eu_gnt` only while `eu_req` is high. They also assume the unit raises `eu_done` only after an `eu_start` pulse, and that memory raises `mem_ready` only while `mem_valid` is high. The bench's unit and memory models react only to the sequencer's own outputs: a grant follows a pending request after two cycles, done follows start after three, and memory acceptance takes 0 to 2 cycles. As a result, none of these inputs ever appears outside the window the design expects.

// File: rtl/chan_pkg.sv
package chan_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH_HDR, S_REQ_EU, S_LOAD, S_RUN,
    S_WRITE_OUT, S_WB_DONE, S_WB_STATUS, S_RELEASE
  } seq_state_e;

  localparam int HDR_PRI_LSB   = 0;
  localparam int HDR_SEC_LSB   = 4;
  localparam int HDR_SNOOP_LSB = 8;
  localparam int HDR_ICV_BIT   = 10;
  localparam int HDR_DONE_BIT  = 31;

  localparam int OFS_INPUT  = 4;
  localparam int OFS_OUTPUT = 8;
  localparam int OFS_STATUS = 12;
endpackage

// File: rtl/ptr_fifo.sv
module ptr_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         pop,
  output logic [W-1:0] out_data,
  output logic         empty,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wr_ix, rd_ix;
  logic [CW-1:0] count;
  logic          push;

  assign in_ready = (count != CW'(DEPTH));
  assign empty    = (count == '0);
  assign push     = in_valid && in_ready;
  assign out_data = slots[rd_ix];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ix    <= '0;
      rd_ix    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) begin
        slots[wr_ix] <= in_data;
        wr_ix <= (wr_ix == AW'(DEPTH - 1)) ? '0 : wr_ix + 1'b1;
      end
      if (pop) rd_ix <= (rd_ix == AW'(DEPTH - 1)) ? '0 : rd_ix + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (!push && pop) count <= count - 1'b1;
      if (in_valid && !in_ready) overflow <= 1'b1;
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_drop_keeps_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !pop) |=> (count == CW'(DEPTH)));
  p_overflow_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/unit_decode.sv
module unit_decode #(
  parameter int NUM_EU = 8
) (
  input  logic [3:0]        pri_code,
  input  logic [3:0]        sec_code,
  input  logic [1:0]        snoop,
  output logic [NUM_EU-1:0] mask
);
  logic sec_used;
  assign sec_used = (snoop != 2'b00);

  for (genvar i = 0; i < NUM_EU; i++) begin : g_unit
    assign mask[i] = (pri_code == 4'(i + 1)) || (sec_used && (sec_code == 4'(i + 1)));
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import chan_pkg::*;
#(
  parameter int NUM_EU = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [ADDR_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic [DATA_W-1:0] hdr,
  input  logic [NUM_EU-1:0] unit_mask,
  output logic              eu_req,
  output logic [NUM_EU-1:0] eu_mask,
  input  logic              eu_gnt,
  output logic              eu_rel,
  output logic              eu_start,
  output logic [1:0]        eu_snoop,
  output logic [DATA_W-1:0] eu_din,
  input  logic              eu_done,
  input  logic [DATA_W-1:0] eu_dout,
  input  logic              eu_icv_ok,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  seq_state_e        state;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] hdr_q, din_q, dout_q;
  logic              icv_q, started_q;

  assign hdr      = hdr_q;
  assign fifo_pop = (state == S_IDLE) && !fifo_empty;
  assign eu_req   = (state == S_REQ_EU);
  assign eu_mask  = unit_mask;
  assign eu_rel   = (state == S_RELEASE);
  assign eu_start = (state == S_RUN) && !started_q;
  assign eu_snoop = hdr_q[HDR_SNOOP_LSB +: 2];
  assign eu_din   = din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr_q     <= '0;
      hdr_q     <= '0;
      din_q     <= '0;
      dout_q    <= '0;
      icv_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (!fifo_empty) begin
          ptr_q <= fifo_data;
          state <= S_FETCH_HDR;
        end
        S_FETCH_HDR: if (mem_ready) begin
          hdr_q <= mem_rdata;
          state <= S_REQ_EU;
        end
        S_REQ_EU: if (eu_gnt) state <= S_LOAD;
        S_LOAD: if (mem_ready) begin
          din_q     <= mem_rdata;
          started_q <= 1'b0;
          state     <= S_RUN;
        end
        S_RUN: begin
          started_q <= 1'b1;
          if (started_q && eu_done) begin
            dout_q <= eu_dout;
            icv_q  <= eu_icv_ok;
            state  <= S_WRITE_OUT;
          end
        end
        S_WRITE_OUT: if (mem_ready) state <= S_WB_DONE;
        S_WB_DONE: if (mem_ready)
          state <= hdr_q[HDR_ICV_BIT] ? S_WB_STATUS : S_RELEASE;
        S_WB_STATUS: if (mem_ready) state <= S_RELEASE;
        S_RELEASE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = '0;
    unique case (state)
      S_FETCH_HDR: mem_valid = 1'b1;
      S_LOAD: begin
        mem_valid = 1'b1;
        mem_addr  = ptr_q + ADDR_W'(OFS_INPUT);
      end
      S_WRITE_OUT: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + ADDR_W'(OFS_OUTPUT);
        mem_wdata = dout_q;
      end
      S_WB_DONE: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = hdr_q;
        mem_wdata[HDR_DONE_BIT] = 1'b1;
      end
      S_WB_STATUS: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + ADDR_W'(OFS_STATUS);
        mem_wdata = DATA_W'(icv_q);
      end
      default: ;
    endcase
  end

  p_no_mem_while_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eu_req |-> !mem_valid);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eu_req && !eu_gnt) |=> (eu_req && $stable(eu_mask)));
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eu_start |=> !eu_start);
  p_rel_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eu_rel |=> !eu_rel);
  p_rel_after_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eu_rel) |-> $past(mem_valid && mem_we && mem_ready));
endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import chan_pkg::*;
#(
  parameter int NUM_EU     = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_valid,
  input  logic [ADDR_W-1:0] ptr_data,
  output logic              ptr_ready,
  output logic              ptr_overflow,
  output logic              eu_req,
  output logic [NUM_EU-1:0] eu_mask,
  input  logic              eu_gnt,
  output logic              eu_rel,
  output logic              eu_start,
  output logic [1:0]        eu_snoop,
  output logic [DATA_W-1:0] eu_din,
  input  logic              eu_done,
  input  logic [DATA_W-1:0] eu_dout,
  input  logic              eu_icv_ok,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              fifo_empty, fifo_pop;
  logic [ADDR_W-1:0] fifo_data;
  logic [DATA_W-1:0] hdr;
  logic [NUM_EU-1:0] unit_mask;

  ptr_fifo #(.DEPTH(FIFO_DEPTH), .W(ADDR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ptr_valid), .in_data(ptr_data), .in_ready(ptr_ready),
    .pop(fifo_pop), .out_data(fifo_data), .empty(fifo_empty),
    .overflow(ptr_overflow)
  );

  unit_decode #(.NUM_EU(NUM_EU)) u_dec (
    .pri_code(hdr[HDR_PRI_LSB +: 4]),
    .sec_code(hdr[HDR_SEC_LSB +: 4]),
    .snoop(hdr[HDR_SNOOP_LSB +: 2]),
    .mask(unit_mask)
  );

  seq_fsm #(.NUM_EU(NUM_EU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .hdr(hdr), .unit_mask(unit_mask),
    .eu_req(eu_req), .eu_mask(eu_mask), .eu_gnt(eu_gnt), .eu_rel(eu_rel),
    .eu_start(eu_start), .eu_snoop(eu_snoop), .eu_din(eu_din),
    .eu_done(eu_done), .eu_dout(eu_dout), .eu_icv_ok(eu_icv_ok),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fifo_empty) && fifo_empty && !$past(mem_valid) && !$past(eu_req) &&
     !$past(eu_start) && !$past(eu_done)) |-> !mem_valid);
endmodule

// File: tb/sim_chan_seq.sv
module sim_chan_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] XK = 32'h5A5A_0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_valid = 1'b0;
  logic [31:0] ptr_data = '0;
  logic        ptr_ready, ptr_overflow;
  logic        eu_req, eu_rel, eu_start;
  logic [7:0]  eu_mask;
  logic        eu_gnt = 1'b0;
  logic [1:0]  eu_snoop;
  logic [31:0] eu_din;
  logic        eu_done = 1'b0;
  logic [31:0] eu_dout = '0;
  logic        eu_icv_ok = 1'b0;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int tests = 0;
  int fails = 0;
  int done_cnt = 0;
  bit finished = 0;

  logic [31:0] mem [256];
  logic [31:0] q_addr[$], q_wd[$], q_din[$];
  logic        q_we[$];
  logic [7:0]  q_mask[$], q_rel[$];
  logic [1:0]  q_snoop[$];

  chan_seq u0 (
    .clk(clk), .rst_n(rst_n), .ptr_valid(ptr_valid), .ptr_data(ptr_data),
    .ptr_ready(ptr_ready), .ptr_overflow(ptr_overflow),
    .eu_req(eu_req), .eu_mask(eu_mask), .eu_gnt(eu_gnt), .eu_rel(eu_rel),
    .eu_start(eu_start), .eu_snoop(eu_snoop), .eu_din(eu_din),
    .eu_done(eu_done), .eu_dout(eu_dout), .eu_icv_ok(eu_icv_ok),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: preload descriptor, offer pointer, push expectations if accepted
  task automatic put_desc(input int slot, input logic [31:0] hdr,
                          input logic [31:0] data, input logic [7:0] mask,
                          output bit accepted);
    logic [31:0] p;
    p = 32'(slot) * 32'h20;
    mem[p[9:2]]     = hdr;
    mem[p[9:2] + 1] = data;
    @(negedge clk);
    ptr_valid = 1'b1;
    ptr_data  = p;
    accepted  = ptr_ready;
    if (accepted) begin
      q_addr.push_back(p);        q_we.push_back(1'b0); q_wd.push_back('0);
      q_addr.push_back(p + 4);    q_we.push_back(1'b0); q_wd.push_back('0);
      q_addr.push_back(p + 8);    q_we.push_back(1'b1); q_wd.push_back(data ^ XK);
      q_addr.push_back(p);        q_we.push_back(1'b1); q_wd.push_back(hdr | 32'h8000_0000);
      if (hdr[10]) begin
        q_addr.push_back(p + 12); q_we.push_back(1'b1); q_wd.push_back({31'b0, ^data});
      end
      q_mask.push_back(mask);
      q_rel.push_back(mask);
      q_snoop.push_back(hdr[9:8]);
      q_din.push_back(data);
    end
  endtask

  // Memory model and scoreboard monitor
  initial begin
    int wait_cnt = 0;
    int lat = 0;
    logic [31:0] ea, ew;
    logic ewe;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
      end else if (rst_n && mem_valid) begin
        if (wait_cnt >= lat) begin
          wait_cnt = 0;
          lat = (lat + 1) % 3;
          check(!eu_req, "R5", "memory request during reservation", 32'(eu_req), 32'h0);
          if (q_addr.size() == 0) begin
            check(1'b0, "R12", "unexpected memory request", mem_addr, 32'h0);
          end else begin
            ea = q_addr.pop_front(); ewe = q_we.pop_front(); ew = q_wd.pop_front();
            check(mem_addr == ea, "R3/R12", "request address", mem_addr, ea);
            check(mem_we == ewe, "R7/R8", "request direction", 32'(mem_we), 32'(ewe));
            if (ewe && mem_addr[3:0] == 4'hC)
              check(mem_wdata == ew, "R9", "status word", mem_wdata, ew);
            else if (ewe && mem_addr[3:0] == 4'h0)
              check(mem_wdata == ew, "R8", "done-flag header", mem_wdata, ew);
            else if (ewe)
              check(mem_wdata == ew, "R7", "output word", mem_wdata, ew);
          end
          mem_rdata = mem[mem_addr[9:2]];
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          mem_ready = 1'b1;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // Execution unit and resource controller model
  initial begin
    int gcnt = 0;
    int rcnt = 0;
    logic [31:0] held;
    logic [7:0] em;
    logic [1:0] es;
    forever begin
      @(negedge clk);
      eu_gnt  = 1'b0;
      eu_done = 1'b0;
      if (rst_n && eu_req) begin
        gcnt++;
        if (gcnt == 2) begin
          gcnt = 0;
          em = (q_mask.size() != 0) ? q_mask.pop_front() : 8'h00;
          check(eu_mask == em, "R4", "requested unit mask", 32'(eu_mask), 32'(em));
          eu_gnt = 1'b1;
        end
      end
      if (rst_n && eu_start) begin
        held = eu_din;
        es = (q_snoop.size() != 0) ? q_snoop.pop_front() : 2'b00;
        check(eu_snoop == es, "R6", "snoop mode", 32'(eu_snoop), 32'(es));
        em = 8'h00;
        if (q_din.size() != 0) begin
          held = q_din.pop_front();
          check(eu_din == held, "R6", "unit input word", eu_din, held);
        end
        rcnt = 3;
      end else if (rcnt > 0) begin
        rcnt--;
        if (rcnt == 0) begin
          eu_done   = 1'b1;
          eu_dout   = held ^ XK;
          eu_icv_ok = ^held;
        end
      end
      if (rst_n && eu_rel) begin
        em = (q_rel.size() != 0) ? q_rel.pop_front() : 8'h00;
        check(eu_mask == em, "R10", "released unit mask", 32'(eu_mask), 32'(em));
        done_cnt++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%0d expected=%0d descriptors", done_cnt, 6);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ptr_ready == 1'b1, "R1", "ptr_ready after reset", 32'(ptr_ready), 32'h1);
    check(ptr_overflow == 1'b0, "R1", "overflow after reset", 32'(ptr_overflow), 32'h0);
    check(!mem_valid && !eu_req && !eu_start && !eu_rel, "R1", "outputs idle after reset",
          {28'b0, mem_valid, eu_req, eu_start, eu_rel}, 32'h0);
    repeat (4) @(negedge clk);
    check(!mem_valid, "R1", "no request with empty queue", 32'(mem_valid), 32'h0);

    // Six back-to-back offers: one is taken into service, four queue, the last is dropped
    put_desc(0, 32'h00AB_0531, 32'hC0DE_0001, 8'h05, acc);
    check(acc, "R2", "offer 0 accepted", 32'(acc), 32'h1);
    put_desc(1, 32'h0012_0002, 32'h1357_9BDF, 8'h02, acc);
    check(acc, "R2", "offer 1 accepted", 32'(acc), 32'h1);
    put_desc(2, 32'h0034_0648, 32'hFFFF_0000, 8'h88, acc);
    check(acc, "R2", "offer 2 accepted", 32'(acc), 32'h1);
    put_desc(3, 32'h0056_0395, 32'h0000_0007, 8'h10, acc);
    check(acc, "R2", "offer 3 accepted", 32'(acc), 32'h1);
    put_desc(4, 32'h0078_0463, 32'h8421_1248, 8'h04, acc);
    check(acc, "R2", "offer 4 accepted", 32'(acc), 32'h1);
    put_desc(5, 32'h0011_0001, 32'h0BAD_0BAD, 8'h01, acc);
    check(!acc, "R2", "offer to full queue refused", 32'(acc), 32'h0);
    @(negedge clk);
    ptr_valid = 1'b0;
    check(ptr_overflow == 1'b1, "R2", "overflow set after drop", 32'(ptr_overflow), 32'h1);

    while (done_cnt < 5) @(negedge clk);
    repeat (10) @(negedge clk);
    check(q_addr.size() == 0, "R12", "all expected requests seen", 32'(q_addr.size()), 32'h0);
    check(done_cnt == 5, "R12", "descriptors completed", 32'(done_cnt), 32'd5);
    check(mem[2] == (32'hC0DE_0001 ^ XK), "R7", "output stored slot 0", mem[2], 32'hC0DE_0001 ^ XK);
    check(mem[8*1+3] == 32'h0, "R9", "no status for slot 1", mem[8*1+3], 32'h0);

    put_desc(6, 32'h009A_0572, 32'h0F0F_F0F1, 8'h42, acc);
    @(negedge clk);
    ptr_valid = 1'b0;
    check(acc, "R2", "offer after drain accepted", 32'(acc), 32'h1);
    while (done_cnt < 6) @(negedge clk);
    repeat (10) @(negedge clk);
    check(q_addr.size() == 0, "R12", "last descriptor complete", 32'(q_addr.size()), 32'h0);
    check(ptr_overflow == 1'b1, "R2", "overflow stays sticky", 32'(ptr_overflow), 32'h1);
    check(mem[8*6] == 32'h809A_0572, "R8", "header done flag in memory", mem[8*6], 32'h809A_0572);
    check(!mem_valid && !eu_req, "R1", "idle after drain", {30'b0, mem_valid, eu_req}, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule